// File: doc/BRIEF.md
# DMA Scatter-List Walker

This block runs one list-type DMA command. Such a command describes a fragmented transfer as a chain of elements. Each element names one contiguous region of main memory and its length in bytes. The command supplies three values: where the chain of elements sits in local memory, how many elements it holds, and the local-memory address where the gathered data is to land.

The walker reads the elements one at a time through a local-memory read port that has a latency of one cycle. It turns each element into a run of bus requests of at most 128 bytes each. It assigns local-memory destinations so that the data of successive elements lies back to back. Once the last request has been acknowledged, it raises a completion pulse.

To keep the request stream dense, the next element is read while the current one is still being cut into requests. Address translation and the data path to memory are handled outside this block.

Top module: `dma_list_walker`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `req_valid`, `desc_rd_en`, `busy` and `done` are low.
- R2: A command is taken only when `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` equals the inverse of `busy`. A command presented while busy has no effect on the requests, the element reads or the completions.
- R3: Element i of a list is read from local byte address `cmd_list_addr + 8*i`, in increasing order of i. The 64-bit element carries the main-memory address in bits 63:32 and the byte count in bits 31:0.
- R4: An element of N bytes becomes ceil(N/128) requests. Every request except the last has length 128, and the last has length N minus 128 times the number of earlier requests. The main addresses start at the element address and each one is the previous address plus the previous length.
- R5: The local address of the first request of a command is `cmd_dst_addr`. Each later request, within an element and across elements, uses the previous local address plus the previous length, modulo 2^LADDR_W.
- R6: An element whose byte count is zero produces no request. The elements that follow it are still processed.
- R7: A command with an element count of zero reads nothing, issues no request, and pulses `done` in the second cycle after it is accepted.
- R8: `done` is a single-cycle pulse that is given once per command. It is never given while an issued request is still unacknowledged, and `busy` is low in the cycle in which `done` is high.
- R9: While `req_valid` is high and `req_ready` is low, the request stays valid and its address and length fields hold their values.
- R10: When every element is longer than 128 bytes and `req_ready` stays high, all requests of a command are accepted on consecutive cycles, including across element boundaries.
- R11: `desc_rd_en` is never high while `busy` is low, and it is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Walker idle and able to take a command |
| cmd_list_addr | input | LADDR_W | Local byte address of the first element |
| cmd_count | input | CNT_W | Number of elements in the list |
| cmd_dst_addr | input | LADDR_W | Local byte address for the first data byte |
| desc_rd_en | output | 1 | Element read strobe |
| desc_rd_addr | output | LADDR_W | Local byte address of the element being read |
| desc_rd_data | input | 64 | Element word, valid the cycle after the strobe |
| req_valid | output | 1 | Bus request present |
| req_ready | input | 1 | Bus request accepted |
| req_main_addr | output | 32 | Main-memory byte address of the request |
| req_local_addr | output | LADDR_W | Local-memory byte address of the request |
| req_len | output | LEN_W | Request length in bytes, 1 to MAX_BURST |
| ack_valid | input | 1 | One accepted request has finished |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Completion pulse |

## Verification
The hardest case to reach from the ports is the element boundary. Here the last slice of one element and the first slice of the next must follow each other with no gap, and the element read for the next one must already have returned. The bench sets this up with lists whose elements each span at least two requests, holds `req_ready` high, and compares the acceptance cycles of all requests. The second hard case is a completion held back by late acknowledgements. The bench withholds acknowledgements until every request has been accepted, waits, and only then releases them.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  // Element word: main address in the upper half, byte count in the lower half.
  typedef struct packed {
    logic [31:0] main_addr;
    logic [31:0] nbytes;
  } dlw_elem_t;
endpackage

// File: rtl/dlw_fetch.sv
module dlw_fetch
  import dlw_pkg::*;
#(
  parameter int LADDR_W = 16,
  parameter int CNT_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [LADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]   start_count,
  output logic               desc_rd_en,
  output logic [LADDR_W-1:0] desc_rd_addr,
  input  logic [63:0]        desc_rd_data,
  output logic               elem_valid,
  output dlw_elem_t          elem,
  input  logic               elem_pop,
  output logic               idle
);
  localparam logic [LADDR_W-1:0] ELEM_BYTES = LADDR_W'(8);

  logic [CNT_W-1:0]   left_q;
  logic [LADDR_W-1:0] ptr_q;
  logic               pend_q;
  logic               hold_v_q;
  dlw_elem_t          hold_q;
  dlw_elem_t          rd_word;
  logic               issue;

  assign rd_word = dlw_elem_t'(desc_rd_data);

  // One element read in flight at most, and only when the holding slot frees.
  assign issue = (left_q != '0) && !pend_q && (!hold_v_q || elem_pop) && !start;

  assign desc_rd_en   = issue;
  assign desc_rd_addr = ptr_q;
  assign elem_valid   = hold_v_q;
  assign elem         = hold_q;
  assign idle         = (left_q == '0) && !pend_q && !hold_v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q   <= '0;
      ptr_q    <= '0;
      pend_q   <= 1'b0;
      hold_v_q <= 1'b0;
      hold_q   <= '0;
    end else if (start) begin
      left_q   <= start_count;
      ptr_q    <= start_addr;
      pend_q   <= 1'b0;
      hold_v_q <= 1'b0;
    end else begin
      pend_q <= issue;
      if (issue) begin
        left_q <= left_q - CNT_W'(1);
        ptr_q  <= ptr_q + ELEM_BYTES;
      end
      if (pend_q) begin
        // Empty elements are dropped here and never reach the splitter.
        hold_v_q <= (rd_word.nbytes != 32'd0);
        hold_q   <= rd_word;
      end else if (elem_pop) begin
        hold_v_q <= 1'b0;
      end
    end
  end

  p_read_spacing_r11: assert property (@(posedge clk) disable iff (rst)
    desc_rd_en |=> !desc_rd_en);

  p_no_empty_elem_r6: assert property (@(posedge clk) disable iff (rst)
    elem_valid |-> (elem.nbytes != 32'd0));
endmodule

// File: rtl/dlw_split.sv
module dlw_split
  import dlw_pkg::*;
#(
  parameter int LADDR_W   = 16,
  parameter int MAX_BURST = 128,
  parameter int LEN_W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [LADDR_W-1:0] start_dst,
  input  logic               elem_valid,
  input  dlw_elem_t          elem,
  output logic               elem_pop,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [31:0]        req_main_addr,
  output logic [LADDR_W-1:0] req_local_addr,
  output logic [LEN_W-1:0]   req_len,
  output logic               idle
);
  localparam logic [31:0]      BURST32  = 32'(MAX_BURST);
  localparam logic [LEN_W-1:0] BURST_LN = LEN_W'(MAX_BURST);

  logic               cur_v_q;
  logic [31:0]        cur_addr_q;
  logic [31:0]        cur_rem_q;
  logic [LADDR_W-1:0] loc_q;
  logic               load;
  logic               last;
  logic [LEN_W-1:0]   slice;
  logic               elem_ready;

  assign last       = (cur_rem_q <= BURST32);
  assign slice      = last ? cur_rem_q[LEN_W-1:0] : BURST_LN;
  assign load       = cur_v_q && (!req_valid || req_ready);
  // Take the next element in the same cycle the current one emits its last slice.
  assign elem_ready = !cur_v_q || (load && last);
  assign elem_pop   = elem_valid && elem_ready;
  assign idle       = !cur_v_q && !req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_v_q        <= 1'b0;
      cur_addr_q     <= '0;
      cur_rem_q      <= '0;
      loc_q          <= '0;
      req_valid      <= 1'b0;
      req_main_addr  <= '0;
      req_local_addr <= '0;
      req_len        <= '0;
    end else begin
      if (start) loc_q <= start_dst;
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (load) begin
        req_valid      <= 1'b1;
        req_main_addr  <= cur_addr_q;
        req_local_addr <= loc_q;
        req_len        <= slice;
        loc_q          <= loc_q + LADDR_W'(slice);
        cur_addr_q     <= cur_addr_q + 32'(slice);
        cur_rem_q      <= cur_rem_q - 32'(slice);
        if (last) cur_v_q <= 1'b0;
      end
      if (elem_pop) begin
        cur_v_q    <= 1'b1;
        cur_addr_q <= elem.main_addr;
        cur_rem_q  <= elem.nbytes;
      end
    end
  end

  p_len_range_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_len != '0) && (req_len <= BURST_LN));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> req_valid && $stable(req_main_addr)
      && $stable(req_local_addr) && $stable(req_len));
endmodule

// File: rtl/dlw_track.sv
module dlw_track #(
  parameter int OUTS_W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic issued,
  input  logic ack,
  output logic none_open
);
  logic [OUTS_W-1:0] open_q;

  assign none_open = (open_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= '0;
    end else if (issued && !ack) begin
      open_q <= open_q + OUTS_W'(1);
    end else if (ack && !issued) begin
      open_q <= open_q - OUTS_W'(1);
    end
  end

  p_ack_needs_open_r8: assert property (@(posedge clk) disable iff (rst)
    ack |-> !none_open);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (issued && !ack) |-> (open_q != {OUTS_W{1'b1}}));
endmodule

// File: rtl/dma_list_walker.sv
module dma_list_walker
  import dlw_pkg::*;
#(
  parameter int LADDR_W   = 16,
  parameter int CNT_W     = 12,
  parameter int MAX_BURST = 128,
  parameter int OUTS_W    = 6,
  localparam int LEN_W    = $clog2(MAX_BURST) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [LADDR_W-1:0] cmd_list_addr,
  input  logic [CNT_W-1:0]   cmd_count,
  input  logic [LADDR_W-1:0] cmd_dst_addr,
  output logic               desc_rd_en,
  output logic [LADDR_W-1:0] desc_rd_addr,
  input  logic [63:0]        desc_rd_data,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [31:0]        req_main_addr,
  output logic [LADDR_W-1:0] req_local_addr,
  output logic [LEN_W-1:0]   req_len,
  input  logic               ack_valid,
  output logic               busy,
  output logic               done
);
  logic      active_q;
  logic      done_q;
  logic      start;
  logic      finish;
  logic      f_idle;
  logic      s_idle;
  logic      none_open;
  logic      e_valid;
  logic      e_pop;
  dlw_elem_t e_word;

  assign cmd_ready = !active_q;
  assign busy      = active_q;
  assign done      = done_q;
  assign start     = cmd_valid && !active_q;
  assign finish    = active_q && f_idle && s_idle && none_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish;
      if (start) active_q <= 1'b1;
      else if (finish) active_q <= 1'b0;
    end
  end

  dlw_fetch #(.LADDR_W(LADDR_W), .CNT_W(CNT_W)) fetch_i (
    .clk(clk), .rst(rst), .start(start),
    .start_addr(cmd_list_addr), .start_count(cmd_count),
    .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr),
    .desc_rd_data(desc_rd_data),
    .elem_valid(e_valid), .elem(e_word), .elem_pop(e_pop),
    .idle(f_idle)
  );

  dlw_split #(.LADDR_W(LADDR_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)) split_i (
    .clk(clk), .rst(rst), .start(start), .start_dst(cmd_dst_addr),
    .elem_valid(e_valid), .elem(e_word), .elem_pop(e_pop),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_main_addr(req_main_addr), .req_local_addr(req_local_addr),
    .req_len(req_len), .idle(s_idle)
  );

  dlw_track #(.OUTS_W(OUTS_W)) track_i (
    .clk(clk), .rst(rst), .issued(req_valid && req_ready),
    .ack(ack_valid), .none_open(none_open)
  );

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !desc_rd_en && !req_valid);

  p_busy_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !done_q && !finish) |=> busy);
endmodule

// File: tb/dma_list_walker_tb.sv
module dma_list_walker_tb_top;
  localparam int LADDR_W = 16;
  localparam int CNT_W   = 12;
  localparam int LEN_W   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [LADDR_W-1:0] cmd_list_addr = '0;
  logic [CNT_W-1:0]   cmd_count = '0;
  logic [LADDR_W-1:0] cmd_dst_addr = '0;
  logic desc_rd_en;
  logic [LADDR_W-1:0] desc_rd_addr;
  logic [63:0] desc_rd_data = '0;
  logic req_valid;
  logic req_ready = 1'b1;
  logic [31:0] req_main_addr;
  logic [LADDR_W-1:0] req_local_addr;
  logic [LEN_W-1:0] req_len;
  logic ack_valid = 1'b0;
  logic busy;
  logic done;

  always #5 clk = ~clk;

  dma_list_walker dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_list_addr(cmd_list_addr), .cmd_count(cmd_count),
    .cmd_dst_addr(cmd_dst_addr), .desc_rd_en(desc_rd_en),
    .desc_rd_addr(desc_rd_addr), .desc_rd_data(desc_rd_data),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_main_addr(req_main_addr), .req_local_addr(req_local_addr),
    .req_len(req_len), .ack_valid(ack_valid), .busy(busy), .done(done)
  );

  logic [63:0] lmem [0:31];
  always @(posedge clk) if (desc_rd_en) desc_rd_data <= lmem[desc_rd_addr[7:3]];

  int nchk = 0;
  int nerr = 0;
  bit all_done = 0;
  int ready_mode = 0;
  bit ack_hold = 0;

  // Monitor state, written only by the posedge monitor.
  int cyc = 0;
  int nrec = 0;
  int nrd = 0;
  int ndone = 0;
  int pend = 0;
  int early_err = 0;
  int hold_err = 0;
  int idle_rd_err = 0;
  logic [31:0] rec_main [0:255];
  logic [15:0] rec_loc  [0:255];
  int          rec_len  [0:255];
  int          rec_cyc  [0:255];
  logic [15:0] rd_log   [0:255];
  bit          prev_stall = 0;
  logic [31:0] prev_main;
  logic [15:0] prev_loc;
  logic [7:0]  prev_len;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (prev_stall && (!req_valid || req_main_addr != prev_main ||
          req_local_addr != prev_loc || req_len != prev_len))
        hold_err <= hold_err + 1;
      prev_stall <= req_valid && !req_ready;
      prev_main  <= req_main_addr;
      prev_loc   <= req_local_addr;
      prev_len   <= req_len;
      if (req_valid && req_ready && nrec < 256) begin
        rec_main[nrec] <= req_main_addr;
        rec_loc[nrec]  <= req_local_addr;
        rec_len[nrec]  <= int'(req_len);
        rec_cyc[nrec]  <= cyc;
        nrec <= nrec + 1;
      end
      if (desc_rd_en && nrd < 256) begin
        rd_log[nrd] <= desc_rd_addr;
        nrd <= nrd + 1;
      end
      if (desc_rd_en && !busy) idle_rd_err <= idle_rd_err + 1;
      if (done) begin
        ndone <= ndone + 1;
        if (pend != 0) early_err <= early_err + 1;
      end
      pend <= pend + ((req_valid && req_ready) ? 1 : 0) - (ack_valid ? 1 : 0);
    end
  end

  always @(negedge clk) begin
    ack_valid <= !ack_hold && (pend > 0);
    req_ready <= (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue_cmd(input int la, input int cnt, input int dst);
    @(negedge clk);
    cmd_list_addr = LADDR_W'(la);
    cmd_count     = CNT_W'(cnt);
    cmd_dst_addr  = LADDR_W'(dst);
    cmd_valid     = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input int d0, input string tag);
    int n = 0;
    while (ndone == d0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(ndone == d0 + 1, tag, ndone - d0, 1);
  endtask

  // Expected stream from the requirements: R3 layout, R4 slicing, R5/R6 packing.
  task automatic check_stream(input int la, input int cnt, input int dst,
                              input int rb, input int db, input string tag);
    int k = 0;
    logic [15:0] loc = 16'(dst);
    bit ok_main = 1, ok_loc = 1, ok_len = 1, ok_rd = 1;
    for (int i = 0; i < cnt; i++) begin
      logic [63:0] e = lmem[((la >> 3) + i) & 31];
      logic [31:0] ma = e[63:32];
      int sz = int'(e[31:0]);
      if (rd_log[db + i] != 16'(la + 8*i)) ok_rd = 0;
      while (sz > 0) begin
        int ln = (sz > 128) ? 128 : sz;
        if (rec_main[rb + k] != ma) ok_main = 0;
        if (rec_loc[rb + k] != loc) ok_loc = 0;
        if (rec_len[rb + k] != ln) ok_len = 0;
        ma = ma + 32'(ln);
        loc = loc + 16'(ln);
        sz = sz - ln;
        k++;
      end
    end
    chk(nrd - db == cnt, {tag, " R3 read count"}, nrd - db, cnt);
    chk(ok_rd, {tag, " R3 read addresses"}, ok_rd, 1);
    chk(nrec - rb == k, {tag, " R4 R6 request count"}, nrec - rb, k);
    chk(ok_main && ok_len, {tag, " R4 main address and length"}, ok_main && ok_len, 1);
    chk(ok_loc, {tag, " R5 local packing"}, ok_loc, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!req_valid && !desc_rd_en && !busy && !done, "R1 during reset",
        {req_valid, desc_rd_en, busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!req_valid && !desc_rd_en && !busy && !done && cmd_ready, "R1 after reset",
        {req_valid, desc_rd_en, busy, done}, 0);
  endtask

  task automatic t_basic;
    int rb = nrec, db = nrd, d0 = ndone;
    issue_cmd(0, 3, 16'h0100);
    wait_done(d0, "R8 basic completion");
    check_stream(0, 3, 16'h0100, rb, db, "basic");
    chk(early_err == 0, "R8 done before acks", early_err, 0);
  endtask

  task automatic t_zero_elems;
    int rb = nrec, db = nrd, d0 = ndone;
    issue_cmd(16'h20, 4, 16'h0400);
    wait_done(d0, "R6 zero-size list completion");
    check_stream(16'h20, 4, 16'h0400, rb, db, "R6 zero-size");
  endtask

  task automatic t_empty;
    int rb = nrec, db = nrd, d0 = ndone;
    issue_cmd(16'h60, 0, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b1, "R7 done timing", done, 1);
    repeat (3) @(negedge clk);
    chk(nrec == rb && nrd == db, "R7 no traffic", (nrec - rb) + (nrd - db), 0);
    chk(ndone == d0 + 1, "R7 one completion", ndone - d0, 1);
  endtask

  task automatic t_backpressure;
    int rb = nrec, db = nrd, d0 = ndone;
    ready_mode = 1;
    issue_cmd(0, 3, 16'h0800);
    wait_done(d0, "R9 completion under stall");
    ready_mode = 0;
    check_stream(0, 3, 16'h0800, rb, db, "R9 stalled");
    chk(hold_err == 0, "R9 request held while stalled", hold_err, 0);
  endtask

  task automatic t_no_gap;
    int rb = nrec, db = nrd, d0 = ndone;
    bit dense = 1;
    issue_cmd(16'h40, 3, 16'h1000);
    wait_done(d0, "R10 completion");
    check_stream(16'h40, 3, 16'h1000, rb, db, "R10 dense");
    for (int i = rb + 1; i < nrec; i++)
      if (rec_cyc[i] != rec_cyc[i-1] + 1) dense = 0;
    chk(dense, "R10 back-to-back across elements", dense, 1);
  endtask

  task automatic t_busy_ignore;
    int rb = nrec, db = nrd, d0 = ndone;
    bit rdy_low = 1;
    issue_cmd(0, 3, 16'h2000);
    cmd_list_addr = 16'h40;
    cmd_count     = 3;
    cmd_dst_addr  = 16'h3000;
    cmd_valid     = 1'b1;
    repeat (3) begin
      @(negedge clk);
      if (cmd_ready) rdy_low = 0;
    end
    cmd_valid = 1'b0;
    chk(rdy_low, "R2 cmd_ready low while busy", rdy_low, 1);
    wait_done(d0, "R2 completion");
    repeat (20) @(negedge clk);
    chk(ndone == d0 + 1, "R2 ignored command gave no completion", ndone - d0, 1);
    check_stream(0, 3, 16'h2000, rb, db, "R2 ignore");
  endtask

  task automatic t_ack_hold;
    int rb = nrec, db = nrd, d0 = ndone;
    int n = 0;
    ack_hold = 1;
    issue_cmd(16'h40, 3, 16'h5000);
    while (nrec - rb < 6 && n < 500) begin
      @(negedge clk);
      n++;
    end
    repeat (12) @(negedge clk);
    chk(ndone == d0, "R8 no done while acks withheld", ndone - d0, 0);
    chk(busy == 1'b1, "R8 busy while acks withheld", busy, 1);
    ack_hold = 0;
    wait_done(d0, "R8 done after release");
    chk(early_err == 0, "R8 done only after last ack", early_err, 0);
    check_stream(16'h40, 3, 16'h5000, rb, db, "R8 held");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) lmem[i] = 64'd0;
    lmem[0]  = {32'h1000_0000, 32'd300};
    lmem[1]  = {32'h2000_0040, 32'd64};
    lmem[2]  = {32'h3000_0000, 32'd129};
    lmem[4]  = {32'h4000_0000, 32'd0};
    lmem[5]  = {32'h4100_0000, 32'd20};
    lmem[6]  = {32'h4200_0000, 32'd0};
    lmem[7]  = {32'h4300_0000, 32'd0};
    lmem[8]  = {32'h5000_0000, 32'd256};
    lmem[9]  = {32'h6000_0010, 32'd200};
    lmem[10] = {32'h7000_0000, 32'd130};
    repeat (3) @(posedge clk);
    t_reset();
    t_basic();
    t_zero_elems();
    t_empty();
    t_backpressure();
    t_no_gap();
    t_busy_ignore();
    t_ack_hold();
    chk(idle_rd_err == 0, "R11 no element read while idle", idle_rd_err, 0);
    all_done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!all_done) begin
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr + 1, nchk + 1);
      $finish;
    end
  end
endmodule